// File: doc/BRIEF.md
# Paging Control Register Unit

This block keeps the paging-related control state of a 32-bit core: the main machine-control word (CR0), the page-directory base (CR3), the paging-extension word (CR4) and a 32-bit address mask driven by an external gate level on address bit 20. Each register is written by its own strobe and 32-bit data bus. From CR0 the block derives five hidden mode flags: protected mode, add-segment, math-present, emulate and task-switched. These flags are for the decode and segmentation logic around the core.

Whenever a write changes state that affects address translation, the block raises a one-cycle TLB flush request for the translation cache next to it. Writes that leave the translation-relevant bits unchanged do not disturb the cache. Writes on the same cycle are combined: CR0 is applied first, and the flush requests they cause are ORed together.

Top module: `paging_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the outputs are as follows. cr0 = 0x60000010, cr3 = 0, cr4 = 0 and a20_mask = 0xFFFFFFFF. hf_prot, hf_mp, hf_em and hf_ts are 0, hf_addseg is 1 and tlb_flush is 0.
- R2: A CR0 write stores the written data with bit 4 forced to 1, whatever value that bit had in the data.
- R3: A CR0 write requests a flush only if it changes at least one of bit 31 (paging on), bit 16 (write protect) or bit 0 (protection on). A change in any other bit gives no flush.
- R4: hf_prot always equals cr0 bit 0. A CR0 write with bit 0 clear sets hf_addseg to 1. hf_addseg is never cleared outside reset, so it is 1 whenever cr0 bit 0 is 0.
- R5: On a CR0 write, hf_mp, hf_em and hf_ts take cr0 bits 1, 2 and 3 of the stored value.
- R6: A CR3 write stores the data unchanged. It requests a flush only when cr0 bit 31 is 1. Without a write, cr3 holds its value.
- R7: A CR4 write stores the data unchanged. It requests a flush only if it changes at least one of bit 4 (large pages), bit 5 (extended addresses) or bit 7 (global pages).
- R8: When a20_en differs from a20_mask bit 20, the mask becomes 0xFFEFFFFF with bit 20 equal to a20_en, and a flush is requested. An a20_en equal to the current mask bit changes nothing and gives no flush.
- R9: Registers and flags update at the clock edge that samples the write. tlb_flush is high for exactly the cycle after that edge, and it is low after an edge with no write and no a20 change.
- R10: When several writes come on one cycle, CR0 is applied first, so the CR3 flush condition sees the bit 31 being written. The flush causes of all writes and of the a20 gate are ORed into one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cr0_we | input | 1 | CR0 write strobe |
| cr0_wdata | input | 32 | CR0 write data |
| cr3_we | input | 1 | CR3 write strobe |
| cr3_wdata | input | 32 | CR3 write data |
| cr4_we | input | 1 | CR4 write strobe |
| cr4_wdata | input | 32 | CR4 write data |
| a20_en | input | 1 | Address bit 20 gate level |
| cr0 | output | 32 | Current CR0 |
| cr3 | output | 32 | Current CR3 |
| cr4 | output | 32 | Current CR4 |
| a20_mask | output | 32 | Address mask applied to bit 20 |
| hf_prot | output | 1 | Hidden protected-mode flag |
| hf_addseg | output | 1 | Hidden add-segment flag |
| hf_mp | output | 1 | Hidden math-present flag |
| hf_em | output | 1 | Hidden emulate flag |
| hf_ts | output | 1 | Hidden task-switched flag |
| tlb_flush | output | 1 | One-cycle TLB flush request |

## Verification
Each result is due one clock edge after its stimulus: the register values, the mask, the flags and tlb_flush all come from a single register stage. The bench therefore drives a stimulus on a falling edge and checks every output on the next falling edge. At that point exactly one rising edge has sampled the write. The bench then releases the strobes, so each stimulus is seen by only that one edge. A bench model checks the flush pulse against the previous state, so a pulse that stays high for a second cycle or comes one cycle late is caught.

// File: rtl/paging_ctl_pkg.sv
package paging_ctl_pkg;

    localparam int unsigned XW = 32;

    // control word bit positions (decoded by neighbouring logic)
    localparam int unsigned BIT_PE  = 0;
    localparam int unsigned BIT_MP  = 1;
    localparam int unsigned BIT_EM  = 2;
    localparam int unsigned BIT_TS  = 3;
    localparam int unsigned BIT_ET  = 4;
    localparam int unsigned BIT_WP  = 16;
    localparam int unsigned BIT_PG  = 31;
    localparam int unsigned BIT_PSE = 4;
    localparam int unsigned BIT_PAE = 5;
    localparam int unsigned BIT_PGE = 7;

    typedef struct packed {
        logic prot;
        logic addseg;
        logic mp;
        logic em;
        logic ts;
    } hflags_t;

    typedef struct packed {
        logic [XW-1:0] cr0;
        logic [XW-1:0] cr3;
        logic [XW-1:0] cr4;
        logic [XW-1:0] mask;
        hflags_t       hf;
        logic          flush;
    } state_t;

endpackage

// File: rtl/paging_ctl_cr0_path.sv
module paging_ctl_cr0_path
    import paging_ctl_pkg::*;
(
    input  logic          we,
    input  logic [XW-1:0] wdata,
    input  logic [XW-1:0] cur,
    input  hflags_t       hf_cur,
    output logic [XW-1:0] nxt,
    output hflags_t       hf_nxt,
    output logic          flush
);
    localparam logic [XW-1:0] ET_MASK    = XW'(1) << BIT_ET;
    localparam logic [XW-1:0] WATCH_MASK = (XW'(1) << BIT_PG) | (XW'(1) << BIT_WP)
                                         | (XW'(1) << BIT_PE);

    logic [XW-1:0] cand;

    always_comb begin
        cand   = wdata | ET_MASK;
        nxt    = cur;
        hf_nxt = hf_cur;
        flush  = 1'b0;
        if (we) begin
            nxt           = cand;
            flush         = |((cand ^ cur) & WATCH_MASK);
            hf_nxt.prot   = cand[BIT_PE];
            hf_nxt.addseg = hf_cur.addseg | ~cand[BIT_PE];
            hf_nxt.mp     = cand[BIT_MP];
            hf_nxt.em     = cand[BIT_EM];
            hf_nxt.ts     = cand[BIT_TS];
        end
    end
endmodule

// File: rtl/paging_ctl_cr4_path.sv
module paging_ctl_cr4_path
    import paging_ctl_pkg::*;
(
    input  logic          we,
    input  logic [XW-1:0] wdata,
    input  logic [XW-1:0] cur,
    output logic [XW-1:0] nxt,
    output logic          flush
);
    localparam logic [XW-1:0] WATCH_MASK = (XW'(1) << BIT_PGE) | (XW'(1) << BIT_PAE)
                                         | (XW'(1) << BIT_PSE);

    always_comb begin
        nxt   = cur;
        flush = 1'b0;
        if (we) begin
            nxt   = wdata;
            flush = |((wdata ^ cur) & WATCH_MASK);
        end
    end
endmodule

// File: rtl/paging_ctl_a20_gate.sv
module paging_ctl_a20_gate
    import paging_ctl_pkg::*;
#(
    parameter int unsigned GATE_BIT = 20
) (
    input  logic          en,
    input  logic [XW-1:0] cur,
    output logic [XW-1:0] nxt,
    output logic          flush
);
    localparam logic [XW-1:0] BASE = ~(XW'(1) << GATE_BIT);

    always_comb begin
        nxt   = cur;
        flush = 1'b0;
        if (en != cur[GATE_BIT]) begin
            nxt   = BASE | (XW'(en) << GATE_BIT);
            flush = 1'b1;
        end
    end
endmodule

// File: rtl/paging_ctl.sv
module paging_ctl
    import paging_ctl_pkg::*;
#(
    parameter logic [31:0] CR0_RESET = 32'h6000_0010,
    parameter int unsigned GATE_BIT  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cr0_we,
    input  logic [31:0] cr0_wdata,
    input  logic        cr3_we,
    input  logic [31:0] cr3_wdata,
    input  logic        cr4_we,
    input  logic [31:0] cr4_wdata,
    input  logic        a20_en,
    output logic [31:0] cr0,
    output logic [31:0] cr3,
    output logic [31:0] cr4,
    output logic [31:0] a20_mask,
    output logic        hf_prot,
    output logic        hf_addseg,
    output logic        hf_mp,
    output logic        hf_em,
    output logic        hf_ts,
    output logic        tlb_flush
);
    localparam logic [XW-1:0] ET_MASK = XW'(1) << BIT_ET;

    state_t        st_d, st_q;
    logic [XW-1:0] cr0_nxt, cr4_nxt, mask_nxt;
    hflags_t       hf_nxt;
    logic          fl_cr0, fl_cr4, fl_a20, fl_cr3;

    paging_ctl_cr0_path u_cr0 (
        .we     (cr0_we),
        .wdata  (cr0_wdata),
        .cur    (st_q.cr0),
        .hf_cur (st_q.hf),
        .nxt    (cr0_nxt),
        .hf_nxt (hf_nxt),
        .flush  (fl_cr0)
    );

    paging_ctl_cr4_path u_cr4 (
        .we    (cr4_we),
        .wdata (cr4_wdata),
        .cur   (st_q.cr4),
        .nxt   (cr4_nxt),
        .flush (fl_cr4)
    );

    paging_ctl_a20_gate #(.GATE_BIT(GATE_BIT)) u_a20 (
        .en    (a20_en),
        .cur   (st_q.mask),
        .nxt   (mask_nxt),
        .flush (fl_a20)
    );

    // CR3 sees the CR0 value of this cycle's write (CR0 applied first)
    assign fl_cr3 = cr3_we & cr0_nxt[BIT_PG];

    always_comb begin
        st_d       = st_q;
        st_d.cr0   = cr0_nxt;
        st_d.cr4   = cr4_nxt;
        st_d.mask  = mask_nxt;
        st_d.hf    = hf_nxt;
        if (cr3_we) begin
            st_d.cr3 = cr3_wdata;
        end
        st_d.flush = fl_cr0 | fl_cr3 | fl_cr4 | fl_a20;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cr0       <= CR0_RESET | ET_MASK;
            st_q.cr3       <= '0;
            st_q.cr4       <= '0;
            st_q.mask      <= '1;
            st_q.hf.prot   <= CR0_RESET[BIT_PE];
            st_q.hf.addseg <= ~CR0_RESET[BIT_PE];
            st_q.hf.mp     <= CR0_RESET[BIT_MP];
            st_q.hf.em     <= CR0_RESET[BIT_EM];
            st_q.hf.ts     <= CR0_RESET[BIT_TS];
            st_q.flush     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr0       = st_q.cr0;
    assign cr3       = st_q.cr3;
    assign cr4       = st_q.cr4;
    assign a20_mask  = st_q.mask;
    assign hf_prot   = st_q.hf.prot;
    assign hf_addseg = st_q.hf.addseg;
    assign hf_mp     = st_q.hf.mp;
    assign hf_em     = st_q.hf.em;
    assign hf_ts     = st_q.hf.ts;
    assign tlb_flush = st_q.flush;

    assert_et_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |=> cr0[BIT_ET]);

    assert_prot_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |=> (hf_prot == $past(cr0_wdata[BIT_PE])));

    assert_addseg_real_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_we && !cr0_wdata[BIT_PE]) |=> hf_addseg);

    assert_cr3_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cr3_we |=> (cr3 == $past(cr3_wdata)));

    assert_cr3_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cr3_we |=> $stable(cr3));

    assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a20_mask | (XW'(1) << GATE_BIT)) == '1);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr0_we && !cr3_we && !cr4_we && (a20_en == a20_mask[GATE_BIT])) |=> !tlb_flush);

    assert_combined_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_we && cr0_wdata[BIT_PG] && cr3_we) |=> tlb_flush);
endmodule

// File: tb/paging_ctl_test.sv
`timescale 1ns/1ps
module paging_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr0_we = 1'b0, cr3_we = 1'b0, cr4_we = 1'b0, a20_en = 1'b1;
    logic [31:0] cr0_wdata = '0, cr3_wdata = '0, cr4_wdata = '0;
    logic [31:0] cr0, cr3, cr4, a20_mask;
    logic        hf_prot, hf_addseg, hf_mp, hf_em, hf_ts, tlb_flush;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_cr0, m_cr3, m_cr4, m_mask;
    logic        m_prot, m_add, m_mp, m_em, m_ts, m_fl;

    always #10 clk = ~clk;

    paging_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .cr0_we(cr0_we), .cr0_wdata(cr0_wdata),
        .cr3_we(cr3_we), .cr3_wdata(cr3_wdata),
        .cr4_we(cr4_we), .cr4_wdata(cr4_wdata),
        .a20_en(a20_en),
        .cr0(cr0), .cr3(cr3), .cr4(cr4), .a20_mask(a20_mask),
        .hf_prot(hf_prot), .hf_addseg(hf_addseg), .hf_mp(hf_mp),
        .hf_em(hf_em), .hf_ts(hf_ts), .tlb_flush(tlb_flush)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(cr0 == m_cr0, {req, " cr0"}, cr0, m_cr0);
        chk(cr3 == m_cr3, {req, " cr3"}, cr3, m_cr3);
        chk(cr4 == m_cr4, {req, " cr4"}, cr4, m_cr4);
        chk(a20_mask == m_mask, {req, " mask"}, a20_mask, m_mask);
        chk({hf_prot, hf_addseg, hf_mp, hf_em, hf_ts} == {m_prot, m_add, m_mp, m_em, m_ts},
            {req, " flags"}, {27'd0, hf_prot, hf_addseg, hf_mp, hf_em, hf_ts},
            {27'd0, m_prot, m_add, m_mp, m_em, m_ts});
        chk(tlb_flush == m_fl, {req, " flush"}, {31'd0, tlb_flush}, {31'd0, m_fl});
    endtask

    // one stimulus cycle: drive at a falling edge, check at the next
    task automatic step(input bit w0, input logic [31:0] d0, input bit w3,
                        input logic [31:0] d3, input bit w4, input logic [31:0] d4,
                        input bit a20, input string req);
        logic [31:0] n0;
        @(negedge clk);
        cr0_we = w0; cr0_wdata = d0;
        cr3_we = w3; cr3_wdata = d3;
        cr4_we = w4; cr4_wdata = d4;
        a20_en = a20;
        m_fl = 1'b0;
        if (w0) begin
            n0 = d0 | 32'h10;
            if (((n0 ^ m_cr0) & 32'h8001_0001) != 0) m_fl = 1'b1;
            m_cr0 = n0;
            m_prot = n0[0];
            if (!n0[0]) m_add = 1'b1;
            m_mp = n0[1]; m_em = n0[2]; m_ts = n0[3];
        end
        if (w3) begin
            m_cr3 = d3;
            if (m_cr0[31]) m_fl = 1'b1;
        end
        if (w4) begin
            if (((d4 ^ m_cr4) & 32'hB0) != 0) m_fl = 1'b1;
            m_cr4 = d4;
        end
        if (a20 != m_mask[20]) begin
            m_mask = 32'hFFEF_FFFF | ({31'd0, a20} << 20);
            m_fl = 1'b1;
        end
        @(negedge clk);
        compare_all(req);
        cr0_we = 1'b0; cr3_we = 1'b0; cr4_we = 1'b0;
        m_fl = 1'b0;
    endtask

    initial begin
        m_cr0 = 32'h6000_0010; m_cr3 = '0; m_cr4 = '0; m_mask = '1;
        m_prot = 0; m_add = 1; m_mp = 0; m_em = 0; m_ts = 0; m_fl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");

        // R2 R3 R4 R5: sweep the seven meaningful CR0 bits in a scrambled order
        for (int i = 0; i < 256; i++) begin
            logic [6:0]  v;
            logic [31:0] d;
            v = 7'((i * 73 + 11) & 127);
            d = '0;
            d[0] = v[0]; d[1] = v[1]; d[2] = v[2]; d[3] = v[3];
            d[4] = v[4]; d[16] = v[5]; d[31] = v[6];
            d[30:29] = 2'(i); d[8] = i[2];
            step(1, d, 0, 0, 0, 0, m_mask[20], "R2 R3 R4 R5 cr0 sweep");
        end

        // R6: CR3 writes with paging off and on
        for (int i = 0; i < 16; i++) begin
            step(1, {i[0], 30'd0, 1'b1}, 0, 0, 0, 0, m_mask[20], "R6 cr0 set");
            step(0, 0, 1, 32'h0101_0101 * (i + 1), 0, 0, m_mask[20], "R6 cr3 write");
            step(0, 0, 0, 0, 0, 0, m_mask[20], "R9 idle after cr3");
        end

        // R7: CR4 sweep over the low byte with changing upper bits
        for (int i = 0; i < 256; i++) begin
            logic [31:0] d;
            d = 32'((i * 29) & 255) | (32'(i) << 12);
            step(0, 0, 0, 0, 1, d, m_mask[20], "R7 cr4 sweep");
        end

        // R8: gate toggles and repeats
        for (int i = 0; i < 24; i++) begin
            step(0, 0, 0, 0, 0, 0, (i % 3) != 1, "R8 a20");
        end

        // R9: pulse lasts one cycle
        step(1, 32'h8000_0001, 0, 0, 0, 0, m_mask[20], "R9 trigger");
        step(0, 0, 0, 0, 0, 0, m_mask[20], "R9 pulse ends");

        // R10: same-cycle combinations
        step(1, 32'h0000_0001, 0, 0, 0, 0, m_mask[20], "R10 paging off");
        step(1, 32'h0000_0001, 1, 32'h1234_5000, 0, 0, m_mask[20], "R10 cr3 paging off");
        step(1, 32'h8000_0001, 1, 32'h2345_6000, 0, 0, m_mask[20], "R10 cr3 with new pg");
        step(1, 32'h0000_0001, 1, 32'h3456_7000, 1, 32'h10, ~m_mask[20], "R10 all ORed");
        step(1, 32'h0000_0001, 1, 32'h4567_8000, 1, 32'h10, m_mask[20], "R10 no cause");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%08h exp=%08h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule